// File: doc/BRIEF.md
# PWM Channel Time-Base with Event Qualifier

This block produces two pulse-width-modulated outputs from one free-running time-base counter. The counter either climbs from zero to a programmed top value and wraps (edge-aligned switching), or climbs to the top value and descends back to zero (centre-aligned switching). Six counter events are decoded every cycle: bottom, top, and a match on each of two compare values while rising or while falling. For each output, every event carries its own two-bit action: leave, drive low, drive high or invert. The two outputs are fully independent.

Several channels can be chained to build interleaved or phase-shifted converters. Each channel flags the counter bottom on a sync output. A slave channel with phase loading enabled jumps its counter to a programmed offset when its sync input pulses, for example a third of the period for a three-phase converter. Any subset of the six events can also raise a one-cycle interrupt pulse or a one-cycle converter start strobe. Software writes the top value, the phase offset, the compare values, the control bits, the action tables and the event selects through a simple write port. It can also force either output directly.

Top module: `pwm_chan`

## Requirements
- R1: After synchronous reset the counter is 0, both outputs, the interrupt and the start strobe are low, every register is zero, and with a zero top value the counter stays at 0.
- R2: With control bit 0 clear (edge-aligned), the counter steps 0,1,…,TOP and then returns to 0, a period of TOP+1 cycles; TOP is written at address 0.
- R3: With control bit 0 set (centre-aligned), the counter steps 0,1,…,TOP,TOP-1,…,1,0,1,…, a period of 2·TOP cycles.
- R4: With control bit 1 set, a high sync_in loads the phase value (address 1) into the counter at the next clock edge, after which it counts upward; with bit 1 clear, sync_in has no effect on the count. Control is written at address 4.
- R5: sync_out is high in exactly those cycles in which the counter is 0.
- R6: Events are indexed bottom=0, top=1, compare A rising=2, compare A falling=3, compare B rising=4, compare B falling=5; the action for event k sits in bits 2k+1:2k of the action word (output A at address 5, output B at address 6), coded 0 none, 1 low, 2 high, 3 invert. An output takes its new level one cycle after the counter shows the event value.
- R7: A high frc_stb applies frc_a and frc_b (same coding, 0 leaves the output to the events) to the outputs at the next edge.
- R8: When events coincide on one output, the level follows the highest-ranked one with a non-zero action: software force, then top, then bottom, then compare B, then compare A.
- R9: Compare values written at addresses 2 (A) and 3 (B) take effect only when the counter is at 0; a change written mid-period leaves the current period's edges untouched.
- R10: The select word at address 7 picks events for the interrupt (bit k for event k) and the start strobe (bit 6+k); each pulses high for one cycle, one cycle after a selected event.
- R11: The actions of output A have no effect on output B and vice versa.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CW | Register write data |
| frc_stb | input | 1 | Software force strobe |
| frc_a | input | 2 | Forced action for output A |
| frc_b | input | 2 | Forced action for output B |
| sync_in | input | 1 | Phase load request from a master channel |
| sync_out | output | 1 | High while the counter is at zero |
| cnt_o | output | CW | Current counter value |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| irq | output | 1 | Interrupt pulse on selected events |
| soc | output | 1 | Converter start pulse on selected events |

## Verification
The counter is run in both counting modes, and the sample-by-sample sequence is compared against the expected one, which tells a correct wrap from a correct turn-around. Action tables are exercised with edges on bottom and compare match in edge-aligned mode, and with rising and falling compare matches in centre-aligned mode. These separate a compare decoded in the wrong direction from one decoded on the correct one. Coincident-event cases put a compare at zero, a compare at top and both compares on the same value, and the outcome differs for each wrong ordering. A mid-period compare write, phase loading with the enable both on and off, and forcing against a same-cycle event show that shadowing, the enable and force precedence each change the observed output.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int NEV   = 6;
    localparam int ACT_W = 2 * NEV;
    localparam int SEL_W = 2 * NEV;

    localparam logic [2:0] ADR_TOP  = 3'd0;
    localparam logic [2:0] ADR_PHS  = 3'd1;
    localparam logic [2:0] ADR_CMPA = 3'd2;
    localparam logic [2:0] ADR_CMPB = 3'd3;
    localparam logic [2:0] ADR_CTL  = 3'd4;
    localparam logic [2:0] ADR_ACTA = 3'd5;
    localparam logic [2:0] ADR_ACTB = 3'd6;
    localparam logic [2:0] ADR_SEL  = 3'd7;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_HIGH = 2'd2,
        ACT_INV  = 2'd3
    } act_e;

    // bit k of the packed struct is event k
    typedef struct packed {
        logic cb_dn;
        logic cb_up;
        logic ca_dn;
        logic ca_up;
        logic top;
        logic bot;
    } ev_t;

    function automatic act_e field(input logic [ACT_W-1:0] acts, input int k);
        return act_e'(acts[2*k +: 2]);
    endfunction

    // lowest rank first, so a higher-ranked active event overwrites it
    function automatic act_e pick_act(input ev_t ev, input logic [ACT_W-1:0] acts);
        act_e r;
        r = ACT_NONE;
        if (ev.ca_up && field(acts, 2) != ACT_NONE) r = field(acts, 2);
        if (ev.ca_dn && field(acts, 3) != ACT_NONE) r = field(acts, 3);
        if (ev.cb_up && field(acts, 4) != ACT_NONE) r = field(acts, 4);
        if (ev.cb_dn && field(acts, 5) != ACT_NONE) r = field(acts, 5);
        if (ev.bot   && field(acts, 0) != ACT_NONE) r = field(acts, 0);
        if (ev.top   && field(acts, 1) != ACT_NONE) r = field(acts, 1);
        return r;
    endfunction

    function automatic logic apply_act(input act_e a, input logic cur);
        case (a)
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            ACT_INV:  return ~cur;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] top,
    input  logic [CW-1:0] phase,
    input  logic          centre,
    input  logic          ph_en,
    input  logic          sync_in,
    output logic [CW-1:0] cnt,
    output logic          cnt_up
);

    localparam logic [CW-1:0] ZERO = '0;
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic load;
    logic at_top;

    assign load   = sync_in & ph_en;
    assign at_top = (cnt >= top);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= ZERO;
            cnt_up <= 1'b1;
        end else if (load) begin
            cnt    <= phase;
            cnt_up <= 1'b1;
        end else if (!centre) begin
            cnt_up <= 1'b1;
            cnt    <= at_top ? ZERO : cnt + ONE;
        end else if (cnt_up) begin
            if (at_top) begin
                if (top == ZERO) begin
                    cnt <= ZERO;
                end else begin
                    cnt    <= top - ONE;
                    cnt_up <= 1'b0;
                end
            end else begin
                cnt <= cnt + ONE;
            end
        end else begin
            if (cnt == ZERO) begin
                cnt    <= (top == ZERO) ? ZERO : ONE;
                cnt_up <= 1'b1;
            end else begin
                cnt <= cnt - ONE;
            end
        end
    end

    // R2: edge-aligned mode wraps to zero after the top value
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (!centre && at_top && !load) |=> (cnt == ZERO));

    // R3: centre-aligned mode turns downward at the top value
    a_r3_turn_down: assert property (@(posedge clk) disable iff (rst)
        (centre && cnt_up && at_top && top != ZERO && !load)
        |=> (!cnt_up && cnt == $past(top) - ONE));

    // R4: a qualified sync loads the phase and counts upward
    a_r4_phase_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(phase) && cnt_up));

endmodule

// File: rtl/pwm_evdecode.sv
module pwm_evdecode
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt,
    input  logic          cnt_up,
    input  logic [CW-1:0] top,
    input  logic [CW-1:0] cmpa,
    input  logic [CW-1:0] cmpb,
    output ev_t           ev
);

    logic hit_a;
    logic hit_b;

    assign hit_a = (cnt == cmpa);
    assign hit_b = (cnt == cmpb);

    always_comb begin
        ev.bot   = (cnt == '0);
        ev.top   = (cnt == top);
        ev.ca_up = hit_a &  cnt_up;
        ev.ca_dn = hit_a & ~cnt_up;
        ev.cb_up = hit_b &  cnt_up;
        ev.cb_dn = hit_b & ~cnt_up;
    end

endmodule

// File: rtl/pwm_qualifier.sv
module pwm_qualifier
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ev_t              ev,
    input  logic [ACT_W-1:0] acts,
    input  logic             frc_stb,
    input  logic [1:0]       frc_act,
    output logic             out
);

    act_e ev_act;
    act_e frc;
    act_e sel_act;

    assign ev_act  = pick_act(ev, acts);
    assign frc     = act_e'(frc_act);
    assign sel_act = (frc_stb && frc != ACT_NONE) ? frc : ev_act;

    always_ff @(posedge clk) begin
        if (rst) out <= 1'b0;
        else     out <= apply_act(sel_act, out);
    end

    // R7: software force outranks every event
    a_r7_force_high: assert property (@(posedge clk) disable iff (rst)
        (frc_stb && frc == ACT_HIGH) |=> out);
    a_r7_force_low: assert property (@(posedge clk) disable iff (rst)
        (frc_stb && frc == ACT_LOW) |=> !out);
    a_r7_force_inv: assert property (@(posedge clk) disable iff (rst)
        (frc_stb && frc == ACT_INV) |=> (out != $past(out)));

    // R6: with no event and no force the output holds
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!frc_stb && ev == '0) |=> $stable(out));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          frc_stb,
    input  logic [1:0]    frc_a,
    input  logic [1:0]    frc_b,
    input  logic          sync_in,
    output logic          sync_out,
    output logic [CW-1:0] cnt_o,
    output logic          pwm_a,
    output logic          pwm_b,
    output logic          irq,
    output logic          soc
);

    localparam int NOUT = 2;

    logic [CW-1:0]    top_r, phs_r;
    logic [CW-1:0]    cmpa_sh, cmpb_sh, cmpa_act, cmpb_act;
    logic [1:0]       ctl_r;
    logic [ACT_W-1:0] act_r [NOUT];
    logic [SEL_W-1:0] sel_r;

    logic [CW-1:0] cnt;
    logic          cnt_up;
    ev_t           ev;
    logic [1:0]    frc_v [NOUT];
    logic          out_v [NOUT];

    // register write port
    always_ff @(posedge clk) begin
        if (rst) begin
            top_r   <= '0;
            phs_r   <= '0;
            cmpa_sh <= '0;
            cmpb_sh <= '0;
            ctl_r   <= '0;
            sel_r   <= '0;
            for (int i = 0; i < NOUT; i++) act_r[i] <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_TOP:  top_r    <= wr_data;
                ADR_PHS:  phs_r    <= wr_data;
                ADR_CMPA: cmpa_sh  <= wr_data;
                ADR_CMPB: cmpb_sh  <= wr_data;
                ADR_CTL:  ctl_r    <= wr_data[1:0];
                ADR_ACTA: act_r[0] <= wr_data[ACT_W-1:0];
                ADR_ACTB: act_r[1] <= wr_data[ACT_W-1:0];
                default:  sel_r    <= wr_data[SEL_W-1:0];
            endcase
        end
    end

    // active compares follow the shadows only at counter zero
    always_ff @(posedge clk) begin
        if (rst) begin
            cmpa_act <= '0;
            cmpb_act <= '0;
        end else if (cnt == '0) begin
            cmpa_act <= cmpa_sh;
            cmpb_act <= cmpb_sh;
        end
    end

    pwm_timebase #(.CW(CW)) u_tb (
        .clk     (clk),
        .rst     (rst),
        .top     (top_r),
        .phase   (phs_r),
        .centre  (ctl_r[0]),
        .ph_en   (ctl_r[1]),
        .sync_in (sync_in),
        .cnt     (cnt),
        .cnt_up  (cnt_up)
    );

    pwm_evdecode #(.CW(CW)) u_ev (
        .cnt    (cnt),
        .cnt_up (cnt_up),
        .top    (top_r),
        .cmpa   (cmpa_act),
        .cmpb   (cmpb_act),
        .ev     (ev)
    );

    assign frc_v[0] = frc_a;
    assign frc_v[1] = frc_b;

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        pwm_qualifier u_aq (
            .clk     (clk),
            .rst     (rst),
            .ev      (ev),
            .acts    (act_r[g]),
            .frc_stb (frc_stb),
            .frc_act (frc_v[g]),
            .out     (out_v[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
            soc <= 1'b0;
        end else begin
            irq <= |(ev & sel_r[NEV-1:0]);
            soc <= |(ev & sel_r[SEL_W-1:NEV]);
        end
    end

    assign sync_out = ev.bot;
    assign cnt_o    = cnt;
    assign pwm_a    = out_v[0];
    assign pwm_b    = out_v[1];

    // R9: active compares never move away from counter zero
    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> ($stable(cmpa_act) && $stable(cmpb_act)));

    // R10: strobes are single-cycle for isolated events
    a_r10_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        (ev == '0) |=> (!irq && !soc));

endmodule

// File: tb/pwm_chan_tb.sv
module pwm_chan_tb;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          frc_stb = 1'b0;
    logic [1:0]    frc_a = '0;
    logic [1:0]    frc_b = '0;
    logic          sync_in = 1'b0;
    logic          sync_out;
    logic [CW-1:0] cnt_o;
    logic          pwm_a, pwm_b, irq, soc;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pwm_chan #(.CW(CW)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frc_stb(frc_stb), .frc_a(frc_a), .frc_b(frc_b), .sync_in(sync_in),
        .sync_out(sync_out), .cnt_o(cnt_o), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .irq(irq), .soc(soc)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int adr, input int dat);
        wr_en   = 1'b1;
        wr_addr = 3'(adr);
        wr_data = CW'(dat);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic cfg(input int ctl, input int top, input int phs, input int ca,
                       input int cb, input int aa, input int ab, input int sel);
        wr(4, ctl); wr(0, top); wr(1, phs); wr(2, ca);
        wr(3, cb);  wr(5, aa);  wr(6, ab);  wr(7, sel);
    endtask

    task automatic wait_cnt(input int v);
        while (int'(cnt_o) != v) @(negedge clk);
    endtask

    task automatic skip(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_frc(input int a, input int b);
        frc_stb = 1'b1; frc_a = 2'(a); frc_b = 2'(b);
        @(negedge clk);
        frc_stb = 1'b0; frc_a = '0; frc_b = '0;
    endtask

    task automatic t_reset;
        chk("R1 count", int'(cnt_o), 0);
        chk("R1 outputs", {pwm_a, pwm_b, irq, soc}, 0);
        chk("R1 sync_out", sync_out, 1);
        skip(3);
        chk("R1 zero top holds count", int'(cnt_o), 0);
    endtask

    task automatic t_edge_count;
        cfg(0, 4, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        wait_cnt(0);
        for (int i = 0; i < 12; i++) begin
            chk("R2 edge-aligned count", int'(cnt_o), i % 5);
            chk("R5 sync_out at zero", sync_out, (i % 5 == 0) ? 1 : 0);
            @(negedge clk);
        end
    endtask

    task automatic t_edge_actions;
        // A: bottom high, compare A rising low; B: bottom low, compare B rising high
        cfg(0, 9, 0, 3, 6, 'h012, 'h201, 0);
        skip(25);
        for (int i = 0; i < 20; i++) begin
            int c;
            c = int'(cnt_o);
            chk("R6 output A edge-aligned", pwm_a, (c >= 1 && c <= 3) ? 1 : 0);
            chk("R11 output B own actions", pwm_b, (c >= 7 || c == 0) ? 1 : 0);
            @(negedge clk);
        end
    endtask

    task automatic t_shadow;
        cfg(0, 9, 0, 3, 6, 'h012, 0, 0);
        skip(25);
        wait_cnt(1);
        wr(2, 6);
        wait_cnt(5);
        chk("R9 old compare kept this period", pwm_a, 0);
        wait_cnt(0);
        wait_cnt(5);
        chk("R9 new compare next period", pwm_a, 1);
        wait_cnt(7);
        chk("R9 new compare edge", pwm_a, 0);
    endtask

    task automatic t_strobes;
        // interrupt on bottom (bit 0), start strobe on compare B rising (bit 6+4)
        cfg(0, 9, 0, 3, 6, 0, 0, 'h401);
        skip(25);
        for (int i = 0; i < 20; i++) begin
            int c;
            c = int'(cnt_o);
            chk("R10 irq after bottom", irq, (c == 1) ? 1 : 0);
            chk("R10 soc after compare B up", soc, (c == 7) ? 1 : 0);
            @(negedge clk);
        end
    endtask

    task automatic t_priority;
        // compare A at zero: bottom(high) beats compare A(low); compare B at top: top(low) beats B(high)
        cfg(0, 5, 0, 0, 5, 'h012, 'h206, 0);
        skip(20);
        for (int i = 0; i < 12; i++) begin
            int c;
            c = int'(cnt_o);
            chk("R8 bottom over compare A", pwm_a, 1);
            chk("R8 top over compare B", pwm_b, (c >= 1) ? 1 : 0);
            @(negedge clk);
        end
        // both compares at 3: B(low) beats A(high)
        cfg(0, 5, 0, 3, 3, 'h121, 0, 0);
        skip(20);
        for (int i = 0; i < 8; i++) begin
            chk("R8 compare B over compare A", pwm_a, 0);
            @(negedge clk);
        end
        // force high on the cycle of a bottom(low) event
        cfg(0, 5, 0, 3, 3, 'h001, 0, 0);
        skip(15);
        wait_cnt(0);
        pulse_frc(2, 0);
        chk("R8 force over bottom event", pwm_a, 1);
    endtask

    task automatic t_force;
        logic b0;
        cfg(0, 9, 0, 3, 6, 0, 0, 0);
        skip(3);
        b0 = pwm_b;
        pulse_frc(2, 0);
        chk("R7 force high", pwm_a, 1);
        pulse_frc(1, 0);
        chk("R7 force low", pwm_a, 0);
        pulse_frc(3, 0);
        chk("R7 force invert", pwm_a, 1);
        pulse_frc(3, 0);
        chk("R7 force invert again", pwm_a, 0);
        chk("R11 B untouched by A force", pwm_b, b0);
        pulse_frc(0, 2);
        chk("R7 force B high", pwm_b, 1);
        chk("R11 A untouched by B force", pwm_a, 0);
    endtask

    task automatic t_centre_count;
        cfg(1, 4, 0, 0, 0, 0, 0, 0);
        skip(12);
        wait_cnt(0);
        for (int i = 0; i < 18; i++) begin
            int m;
            m = i % 8;
            chk("R3 centre-aligned count", int'(cnt_o), (m <= 4) ? m : 8 - m);
            chk("R5 sync_out centre mode", sync_out, (m == 0) ? 1 : 0);
            @(negedge clk);
        end
    endtask

    task automatic t_centre_actions;
        logic b0;
        int   prev;
        // A: compare A rising high (bits 5:4), compare A falling low (bits 7:6)
        cfg(1, 8, 0, 3, 0, 'h060, 0, 0);
        skip(40);
        b0   = pwm_b;
        prev = int'(cnt_o);
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            int c;
            c = int'(cnt_o);
            chk("R6 output A centre-aligned", pwm_a, (c >= 4 || (c == 3 && prev == 4)) ? 1 : 0);
            chk("R11 B idle with no actions", pwm_b, b0);
            prev = c;
            @(negedge clk);
        end
    endtask

    task automatic t_sync;
        cfg(2, 9, 7, 0, 0, 0, 0, 0);
        wait_cnt(2);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        chk("R4 phase loaded", int'(cnt_o), 7);
        @(negedge clk);
        chk("R4 counts on from phase", int'(cnt_o), 8);
        wr(4, 0);
        wait_cnt(2);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        chk("R4 sync ignored when disabled", int'(cnt_o), 3);
        cfg(3, 9, 4, 0, 0, 0, 0, 0);
        wait_cnt(7);
        skip(4);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        chk("R4 centre phase loaded", int'(cnt_o), 4);
        @(negedge clk);
        chk("R4 centre counts upward after load", int'(cnt_o), 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_edge_count();
        t_edge_actions();
        t_shadow();
        t_strobes();
        t_priority();
        t_force();
        t_centre_count();
        t_centre_actions();
        t_sync();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule